// File: doc/BRIEF.md
# Single-Wire Auto-Baud Debug Serial Engine

This block is a half-duplex asynchronous serial engine for a single open-drain debug wire that a host and the chip share. There is no programmed divisor. After reset the engine does nothing until a character arrives. It treats that first character as a rate probe: the value 0x80 holds the wire low for exactly eight bit times, and the engine measures that low time in system clocks.

Once the engine has locked to the measured period, it receives frames from the wire and hands each byte to the debug logic as a one-cycle strobe. It also accepts reply bytes through a valid/ready handshake and sends them back at the same rate. The engine only ever pulls the wire low. A reply may start as soon as the stop bit of a request has been sampled, while the host is still in its stop interval. While the engine is sending, it ignores its own bits as they come back on the receive path. A lost-lock input discards the measurement and returns the engine to waiting for a new probe character.

Top module: `abw_debug_uart`

## Requirements
- R1: Out of reset the engine is unlocked. It releases the wire (drive-low output 0), raises no receive strobe and holds tx_ready_o low.
- R2: The first character after reset, or after lock is lost, must be 0x80. The engine counts the cycles its synchronized wire stays low and locks with a bit period of that count divided by 8 (truncated). It then raises locked_o, and the probe character is not delivered as data.
- R3: If the measured period is below MIN_BIT_CLKS, the engine stays unlocked and treats the next falling edge as a new probe.
- R4: If the wire stays low beyond the range of the CNT_W-bit counter, the engine stays unlocked. It waits for the wire to go high and then measures again.
- R5: Received frames are one low start bit, then 8 data bits least significant first, then a stop bit. Each bit is sampled near its middle using the learned period. Each frame gives a one-cycle rx_valid_o with the byte on rx_data_o.
- R6: A frame whose stop bit is sampled low is still delivered, with rx_frame_err_o = 1. Reception continues with the next falling edge once the wire has returned high.
- R7: A byte accepted on the handshake is sent starting in the cycle after acceptance. The start bit drives low, a 0 data bit drives low and a 1 data bit releases, least significant bit first, and the stop bit releases. Each bit lasts exactly one learned period.
- R8: tx_ready_o is high only while the engine is locked, not sending and not receiving. It rises as soon as a request's stop bit has been sampled, so a reply can begin while the host is still in its stop interval.
- R9: While the engine sends, no receive strobe is produced, either during the frame or because of its echo.
- R10: lock_lost_i high at a clock edge clears the lock, abandons any frame in progress, releases the wire and drops tx_ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Present level of the shared wire |
| line_drive_low_o | output | 1 | 1 pulls the wire low, 0 releases it to the pull-up |
| lock_lost_i | input | 1 | Discards the learned rate and returns to probe hunting |
| locked_o | output | 1 | A bit period has been learned |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_frame_err_o | output | 1 | Stop bit of the presented byte was sampled low |
| tx_valid_i | input | 1 | Reply byte offered |
| tx_data_i | input | 8 | Reply byte |
| tx_ready_o | output | 1 | Engine can accept a reply byte this cycle |

## Verification
Three kinds of probe character are used. One is too fast, one holds the wire low past the counter range, and one is valid. Together they separate rejection for a short period, rejection for overflow, and a correct lock. The learned period is then confirmed by the exact bit lengths of transmitted replies at two different rates, 16 and 20 clocks, before and after a lost-lock relock. The received bytes 0xA5, 0x3C, 0x00 and 0xFF catch bit-order and sampling-phase errors. A request with its stop bit held low separates framing detection from normal reception. A reply launched during the host's stop interval shows both the early-reply path and that the engine's own echo is discarded.

// File: rtl/abw_pkg.sv
package abw_pkg;

  localparam int unsigned DATA_BITS = 8;

  typedef enum logic [1:0] {
    MS_HUNT,
    MS_COUNT,
    MS_DRAIN,
    MS_LOCKED
  } meter_st_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_STOP
  } rx_st_e;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_START,
    TS_DATA,
    TS_STOP
  } tx_st_e;

endpackage

// File: rtl/abw_line_sync.sv
module abw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              prev_q;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = prev_q & ~pipe_q[STAGES-1];

endmodule

// File: rtl/abw_rate_meter.sv
module abw_rate_meter
  import abw_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int MIN_BIT_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             line_i,
  input  logic             fall_i,
  output logic             locked_o,
  output logic [CNT_W-4:0] period_o
);

  localparam int PER_W = CNT_W - 3;
  localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_BIT_CLKS);

  meter_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] eighth;

  // low time of the 0x80 probe covers eight bit periods
  assign eighth = cnt_q[CNT_W-1:3];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    per_d = per_q;
    unique case (st_q)
      MS_HUNT: begin
        if (fall_i) begin
          st_d  = MS_COUNT;
          cnt_d = CNT_W'(1);
        end
      end
      MS_COUNT: begin
        if (line_i) begin
          if (eighth >= MIN_P) begin
            st_d  = MS_LOCKED;
            per_d = eighth;
          end else begin
            st_d = MS_HUNT;
          end
        end else if (&cnt_q) begin
          st_d = MS_DRAIN;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      MS_DRAIN: begin
        if (line_i) st_d = MS_HUNT;
      end
      MS_LOCKED: begin
        st_d = MS_LOCKED;
      end
      default: st_d = MS_HUNT;
    endcase
    if (clear_i) st_d = MS_HUNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_HUNT;
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign locked_o = (st_q == MS_LOCKED);
  assign period_o = per_q;

endmodule

// File: rtl/abw_rx.sv
module abw_rx
  import abw_pkg::*;
#(
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             line_i,
  input  logic             fall_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             err_o
);

  localparam logic [2:0] LAST_BIT = 3'(DATA_BITS - 1);

  rx_st_e           st_q, st_d;
  logic [PER_W-1:0] tmr_q, tmr_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             cap;
  logic             tick;
  logic [PER_W-1:0] half;
  logic [PER_W-1:0] reload;
  logic             valid_q;
  logic [7:0]       data_q;
  logic             err_q;

  assign tick   = (tmr_q == '0);
  assign half   = {1'b0, period_i[PER_W-1:1]};
  assign reload = period_i - PER_W'(1);

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    cap   = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
        if (fall_i && !hold_i) begin
          st_d  = RS_START;
          tmr_d = half;
        end
      end
      RS_START: begin
        if (tick) begin
          if (line_i) begin
            st_d = RS_IDLE;
          end else begin
            st_d  = RS_DATA;
            tmr_d = reload;
            bit_d = '0;
          end
        end else begin
          tmr_d = tmr_q - PER_W'(1);
        end
      end
      RS_DATA: begin
        if (tick) begin
          sh_d  = {line_i, sh_q[7:1]};
          tmr_d = reload;
          if (bit_q == LAST_BIT) st_d = RS_STOP;
          else                   bit_d = bit_q + 3'd1;
        end else begin
          tmr_d = tmr_q - PER_W'(1);
        end
      end
      RS_STOP: begin
        if (tick) begin
          cap  = 1'b1;
          st_d = RS_IDLE;
        end else begin
          tmr_d = tmr_q - PER_W'(1);
        end
      end
      default: st_d = RS_IDLE;
    endcase
    if (!en_i) begin
      st_d = RS_IDLE;
      cap  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      valid_q <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (cap) begin
      data_q <= sh_q;
      err_q  <= ~line_i;
    end
  end

  assign busy_o  = (st_q != RS_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign err_o   = err_q;

endmodule

// File: rtl/abw_tx.sv
module abw_tx
  import abw_pkg::*;
#(
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             rx_busy_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  output logic             active_o,
  output logic             drive_low_o
);

  localparam logic [2:0] LAST_BIT = 3'(DATA_BITS - 1);

  tx_st_e           st_q, st_d;
  logic [PER_W-1:0] tmr_q, tmr_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             tick;
  logic             accept;
  logic [PER_W-1:0] reload;

  assign tick    = (tmr_q == '0);
  assign reload  = period_i - PER_W'(1);
  assign ready_o = en_i && (st_q == TS_IDLE) && !rx_busy_i;
  assign accept  = valid_i && ready_o;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    unique case (st_q)
      TS_IDLE: begin
        if (accept) begin
          st_d  = TS_START;
          sh_d  = data_i;
          tmr_d = reload;
        end
      end
      TS_START: begin
        if (tick) begin
          st_d  = TS_DATA;
          tmr_d = reload;
          bit_d = '0;
        end else begin
          tmr_d = tmr_q - PER_W'(1);
        end
      end
      TS_DATA: begin
        if (tick) begin
          sh_d  = {1'b0, sh_q[7:1]};
          tmr_d = reload;
          if (bit_q == LAST_BIT) st_d = TS_STOP;
          else                   bit_d = bit_q + 3'd1;
        end else begin
          tmr_d = tmr_q - PER_W'(1);
        end
      end
      TS_STOP: begin
        if (tick) st_d = TS_IDLE;
        else      tmr_d = tmr_q - PER_W'(1);
      end
      default: st_d = TS_IDLE;
    endcase
    if (!en_i) st_d = TS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TS_IDLE;
      tmr_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign active_o    = (st_q != TS_IDLE) || accept;
  assign drive_low_o = (st_q == TS_START) || ((st_q == TS_DATA) && !sh_q[0]);

endmodule

// File: rtl/abw_debug_uart.sv
module abw_debug_uart #(
  parameter int CNT_W        = 16,
  parameter int MIN_BIT_CLKS = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       line_drive_low_o,
  input  logic       lock_lost_i,
  output logic       locked_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       rx_frame_err_o,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_ready_o
);

  localparam int PER_W = CNT_W - 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             line_s;
  logic             line_fall;
  logic             locked;
  logic [PER_W-1:0] period;
  logic             engine_en;
  logic             rx_busy;
  logic             tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign engine_en = locked && !lock_lost_i;

  abw_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .line_i (line_i),
    .line_o (line_s),
    .fall_o (line_fall)
  );

  abw_rate_meter #(
    .CNT_W        (CNT_W),
    .MIN_BIT_CLKS (MIN_BIT_CLKS)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (lock_lost_i),
    .line_i   (line_s),
    .fall_i   (line_fall),
    .locked_o (locked),
    .period_o (period)
  );

  abw_rx #(
    .PER_W (PER_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (engine_en),
    .hold_i   (tx_active),
    .period_i (period),
    .line_i   (line_s),
    .fall_i   (line_fall),
    .busy_o   (rx_busy),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .err_o    (rx_frame_err_o)
  );

  abw_tx #(
    .PER_W (PER_W)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (engine_en),
    .period_i    (period),
    .rx_busy_i   (rx_busy),
    .valid_i     (tx_valid_i),
    .data_i      (tx_data_i),
    .ready_o     (tx_ready_o),
    .active_o    (tx_active),
    .drive_low_o (line_drive_low_o)
  );

  assign locked_o = locked;

endmodule

// File: rtl/abw_debug_uart_chk.sv
module abw_debug_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_lost_i,
  input logic locked_o,
  input logic rx_valid_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic line_drive_low_o
);

  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !lock_lost_i) |=> locked_o);

  p_rx_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_start_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> line_drive_low_o);

  p_ready_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> locked_o);

  p_no_rx_while_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low_o |-> !rx_valid_o);

  p_lost_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost_i |=> (!locked_o && !line_drive_low_o));

  p_unlocked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (!line_drive_low_o && !tx_ready_o));

endmodule

bind abw_debug_uart abw_debug_uart_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .lock_lost_i      (lock_lost_i),
  .locked_o         (locked_o),
  .rx_valid_o       (rx_valid_o),
  .tx_valid_i       (tx_valid_i),
  .tx_ready_o       (tx_ready_o),
  .line_drive_low_o (line_drive_low_o)
);

// File: tb/abw_debug_uart_bench.sv
`timescale 1ns/1ps
module abw_debug_uart_bench;

  localparam int CNT_W   = 12;
  localparam int MIN_BIT = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_rel;
  logic       lock_lost;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       drive_low;
  logic       locked;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_err;
  logic       tx_ready;
  logic       line_w;

  int         errors = 0;
  int         checks = 0;
  int         exp_per = 0;
  int         rx_cnt = 0;
  bit         host_busy = 1'b0;
  bit         done = 1'b0;
  logic [8:0] rxq[$];
  bit         dq[$];

  always #2.5 clk = ~clk;

  assign line_w = host_rel & ~drive_low;

  abw_debug_uart #(
    .CNT_W        (CNT_W),
    .MIN_BIT_CLKS (MIN_BIT),
    .SYNC_STAGES  (2)
  ) u_abw_debug_uart (
    .clk              (clk),
    .rst_n            (rst_n),
    .line_i           (line_w),
    .line_drive_low_o (drive_low),
    .lock_lost_i      (lock_lost),
    .locked_o         (locked),
    .rx_valid_o       (rx_valid),
    .rx_data_o        (rx_data),
    .rx_frame_err_o   (rx_err),
    .tx_valid_i       (tx_valid),
    .tx_data_i        (tx_data),
    .tx_ready_o       (tx_ready)
  );

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // reference model: expected wire drive and received bytes, every clock
  always @(negedge clk) begin
    bit         e;
    logic [8:0] x;
    if (rst_n && !done) begin
      e = (dq.size() > 0) ? dq.pop_front() : 1'b0;
      chk(drive_low === e, "R7", int'(drive_low), int'(e), "wire drive level");
      if (rx_valid) begin
        rx_cnt++;
        if (rxq.size() == 0) begin
          chk(1'b0, "R9", int'({rx_err, rx_data}), 0, "unexpected receive strobe");
        end else begin
          x = rxq.pop_front();
          chk({rx_err, rx_data} === x, x[8] ? "R6" : "R5",
              int'({rx_err, rx_data}), int'(x), "received byte");
        end
      end
      if (lock_lost) dq.delete();
      if (tx_valid && tx_ready) begin
        for (int i = 0; i < exp_per; i++) dq.push_back(1'b1);
        for (int b = 0; b < 8; b++)
          for (int i = 0; i < exp_per; i++) dq.push_back(~tx_data[b]);
        for (int i = 0; i < exp_per; i++) dq.push_back(1'b0);
      end
    end
  end

  task automatic hold_level(bit v, int n);
    host_rel = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(logic [7:0] b, int p, bit stop_hi, bit expect_rx);
    if (expect_rx) rxq.push_back({~stop_hi, b});
    hold_level(1'b0, p);
    for (int i = 0; i < 8; i++) hold_level(b[i], p);
    hold_level(stop_hi, p);
    host_rel = 1'b1;
  endtask

  task automatic realign();
    @(posedge clk);
    #1;
  endtask

  task automatic send_reply(logic [7:0] b);
    tx_valid = 1'b1;
    tx_data  = b;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    realign();
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_done();
    while (dq.size() > 0) @(negedge clk);
    realign();
  endtask

  task automatic wait_rx_drain();
    while (rxq.size() > 0) @(negedge clk);
    realign();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    rst_n     = 1'b0;
    host_rel  = 1'b1;
    lock_lost = 1'b0;
    tx_valid  = 1'b0;
    tx_data   = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    @(negedge clk);
    chk(locked == 1'b0,    "R1", int'(locked),    0, "locked after reset");
    chk(drive_low == 1'b0, "R1", int'(drive_low), 0, "drive after reset");
    chk(rx_valid == 1'b0,  "R1", int'(rx_valid),  0, "rx strobe after reset");
    chk(tx_ready == 1'b0,  "R1", int'(tx_ready),  0, "tx_ready after reset");
    realign();

    // R8 no acceptance while unlocked
    tx_valid = 1'b1;
    tx_data  = 8'h55;
    repeat (20) begin
      @(negedge clk);
      chk(tx_ready == 1'b0, "R8", int'(tx_ready), 0, "ready while unlocked");
    end
    realign();
    tx_valid = 1'b0;

    // R3 probe too fast: period 4 < MIN_BIT
    send_frame(8'h80, 4, 1'b1, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(locked == 1'b0, "R3", int'(locked), 0, "lock after short probe");
    realign();

    // R4 low time beyond counter range
    hold_level(1'b0, 4200);
    hold_level(1'b1, 20);
    @(negedge clk);
    chk(locked == 1'b0, "R4", int'(locked), 0, "lock after overflow");
    realign();

    // R2 valid probe at 16 clocks per bit
    send_frame(8'h80, 16, 1'b1, 1'b0);
    exp_per = 16;
    @(negedge clk);
    chk(locked == 1'b1, "R2", int'(locked), 1, "lock after probe");
    realign();

    // R5 reception of several patterns
    base = rx_cnt;
    send_frame(8'hA5, 16, 1'b1, 1'b1);
    send_frame(8'h3C, 16, 1'b1, 1'b1);
    send_frame(8'h00, 16, 1'b1, 1'b1);
    send_frame(8'hFF, 16, 1'b1, 1'b1);
    hold_level(1'b1, 20);
    wait_rx_drain();
    chk(rx_cnt == base + 4, "R5", rx_cnt - base, 4, "received frame count");

    // R6 stop bit low, then recovery
    base = rx_cnt;
    send_frame(8'h5A, 16, 1'b0, 1'b1);
    hold_level(1'b1, 20);
    send_frame(8'hC7, 16, 1'b1, 1'b1);
    hold_level(1'b1, 20);
    wait_rx_drain();
    chk(rx_cnt == base + 2, "R6", rx_cnt - base, 2, "frames around framing error");

    // R8 reply launched during request stop bit; R9 echo ignored
    base = rx_cnt;
    fork
      begin
        host_busy = 1'b1;
        send_frame(8'h11, 16, 1'b1, 1'b1);
        host_busy = 1'b0;
      end
      begin
        while (rx_cnt == base) @(negedge clk);
        realign();
        send_reply(8'h96);
        chk(host_busy == 1'b1, "R8", int'(host_busy), 1, "reply accepted inside stop bit");
      end
    join
    wait_tx_done();
    repeat (10) @(posedge clk);
    #1;
    chk(rx_cnt == base + 1 && rxq.size() == 0, "R9", rx_cnt - base, 1, "strobes across own reply");

    // R7 back-to-back replies
    send_reply(8'hC3);
    send_reply(8'h01);
    wait_tx_done();
    chk(dq.size() == 0, "R7", dq.size(), 0, "reply bits outstanding");

    // R10 lock lost mid-reply
    send_reply(8'hF0);
    repeat (30) @(posedge clk);
    #1 lock_lost = 1'b1;
    realign();
    lock_lost = 1'b0;
    @(negedge clk);
    chk(locked == 1'b0,    "R10", int'(locked),    0, "lock after loss");
    chk(drive_low == 1'b0, "R10", int'(drive_low), 0, "drive after loss");
    chk(tx_ready == 1'b0,  "R10", int'(tx_ready),  0, "ready after loss");
    realign();
    repeat (200) @(posedge clk);
    #1;

    // R2 relock at 20 clocks per bit, then traffic at the new rate
    send_frame(8'h80, 20, 1'b1, 1'b0);
    exp_per = 20;
    @(negedge clk);
    chk(locked == 1'b1, "R2", int'(locked), 1, "relock after loss");
    realign();
    base = rx_cnt;
    send_frame(8'h6B, 20, 1'b1, 1'b1);
    hold_level(1'b1, 20);
    wait_rx_drain();
    chk(rx_cnt == base + 1, "R5", rx_cnt - base, 1, "frame at relearned rate");
    send_reply(8'h5C);
    wait_tx_done();

    chk(rxq.size() == 0 && dq.size() == 0, "R7", int'(rxq.size() + dq.size()), 0,
        "model queues empty at end");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule